// File: doc/BRIEF.md
# Per-Processor Counter/Timer Set with User Mode

This block holds a parameterised number of processor timers and one shared configuration register. Each timer has two personalities. By default it is a limit counter: a 22-bit period count that advances on each tick, wraps to zero when it meets its programmed limit, and raises that processor's interrupt. When software sets the processor's bit in the configuration register, the timer becomes a user timer instead: a 54-bit count presented as a 64-bit value across two 32-bit words, started and stopped by software, which records wrap-around in a reached flag but never interrupts.

Software reaches each processor's four-word window by asserting a read or write strobe with `bus_sys` low and the processor index on `bus_cpu`. With `bus_sys` high it reaches the system window, where word 4 is the configuration register. Read data is registered and appears the cycle after the read strobe. Read side effects happen on that same edge. A `tick` input sets the count rate.

Top module: `cpu_timer_set`

## Requirements
- R1: After reset the configuration register is 0, every interrupt is low, every timer is in counter mode and running with count 0 and limit 0, and word 3 of each processor window reads 1.
- R2: In counter mode each tick adds one to the count. Word 1 reads the reached flag in bit 31 and the count in bits 30:9, with bits 8:0 zero. When the incremented count equals the limit (limit 0 acts as 0x3FFFFF), the count becomes 0, the reached flag is set and the interrupt rises.
- R3: In counter mode, a read of word 0 returns the reached flag in bit 31 and the limit in bits 30:9. The same read clears the reached flag and the interrupt.
- R4: In counter mode, a write to word 0 loads the limit from bits 30:9, zeroes the count and clears the reached flag and the interrupt. A write to word 2 loads the limit and leaves the count and the flag unchanged.
- R5: In counter mode, writes to word 1 and word 3 change nothing. Word 2 reads 0.
- R6: The configuration register is word 4 (byte offset 0x10) of the system window, and bit i selects user mode for processor i. A write to it reads back, and other system words read 0.
- R7: Setting a configuration bit drops that processor's interrupt, stops its timer and clears its count, limit and reached flag.
- R8: In user mode, writing 1 to bit 0 of word 3 starts the timer and writing 0 stops it. Word 3 reads the run state in bit 0, and a stopped timer ignores ticks.
- R9: In user mode, a write to word 0 loads count bits 62:32 from data bits 30:0, and a write to word 1 loads count bits 31:9 from data bits 31:9. Word 0 reads {reached, count[62:32]}, and word 1 reads count[31:0].
- R10: In user mode, a read of word 0 captures the low word. The next read of word 1 returns that captured value once, and later reads return the live count.
- R11: In user mode, when the count wraps from all ones to 0 the reached flag is set and the interrupt stays low.
- R12: Clearing a configuration bit returns that processor to counter mode, running, with count 0, limit 0 and reached flag cleared.
- R13: Counts change only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sys | input | 1 | 1 selects the system window, 0 a processor window |
| bus_cpu | input | CW | Processor index for processor windows |
| bus_word | input | 3 | Word index within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | NCPU | One interrupt per processor |

## Verification
A wrong mode bit or run flag shows at the ports as soon as word 3 or the configuration word is read. A wrong mode bit also shows after a single tick, as a count that moved when it should not have or stayed still when it should have moved. A lost or stale reached flag shows in bit 31 on the next word-0 or word-1 read, and a wrong interrupt shows on `irq` on the edge after the tick that reaches the limit. A broken capture path shows only in the user-mode word-1 read that follows a word-0 read across a low-word carry, so the checks place one tick exactly in that gap.

// File: rtl/cpu_timer_set.sv
module cpu_timer_set #(
  parameter int NCPU = 2,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_sys,
  input  logic [CW-1:0]   bus_cpu,
  input  logic [2:0]      bus_word,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCPU-1:0] irq
);
  localparam int CNTW = 54;
  localparam int LIMW = 22;
  localparam logic [2:0] CFG_WORD = 3'd4;

  logic [CNTW-1:0] cnt  [NCPU];
  logic [LIMW-1:0] lim  [NCPU];
  logic [31:0]     snap [NCPU];
  logic [NCPU-1:0] run, rch, svld, cfg, irq_q;
  logic [31:0]     rd_v;

  wire cpu_wr  = bus_wr && !bus_sys;
  wire cpu_rd  = bus_rd && !bus_sys;
  wire cfg_wr  = bus_wr && bus_sys && bus_word == CFG_WORD;

  assign irq = irq_q;

  always_comb begin
    rd_v = '0;
    if (bus_sys) begin
      if (bus_word == CFG_WORD) rd_v[NCPU-1:0] = cfg;
    end else begin
      case (bus_word)
        3'd0: rd_v = cfg[bus_cpu] ? {rch[bus_cpu], cnt[bus_cpu][CNTW-1:23]}
                                  : {rch[bus_cpu], lim[bus_cpu], 9'b0};
        3'd1: rd_v = cfg[bus_cpu] ? (svld[bus_cpu] ? snap[bus_cpu] : {cnt[bus_cpu][22:0], 9'b0})
                                  : {rch[bus_cpu], cnt[bus_cpu][LIMW-1:0], 9'b0};
        3'd3: rd_v[0] = run[bus_cpu];
        default: rd_v = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      cfg   <= '0;
      run   <= '1;
      rch   <= '0;
      svld  <= '0;
      irq_q <= '0;
      for (int i = 0; i < NCPU; i++) begin
        cnt[i]  <= '0;
        lim[i]  <= '0;
        snap[i] <= '0;
      end
    end else begin
      if (bus_rd) bus_rdata <= rd_v;
      for (int i = 0; i < NCPU; i++) begin
        // read side effects first, so a same-cycle reach is not lost
        if (cpu_rd && bus_cpu == CW'(i)) begin
          if (!cfg[i] && bus_word == 3'd0) begin
            rch[i]   <= 1'b0;
            irq_q[i] <= 1'b0;
          end
          if (cfg[i] && bus_word == 3'd0) begin
            snap[i] <= {cnt[i][22:0], 9'b0};
            svld[i] <= 1'b1;
          end
          if (cfg[i] && bus_word == 3'd1) svld[i] <= 1'b0;
        end

        if (tick && run[i]) begin
          if (cfg[i]) begin
            cnt[i] <= cnt[i] + CNTW'(1);
            if (&cnt[i]) rch[i] <= 1'b1;
          end else if ((cnt[i][LIMW-1:0] + LIMW'(1)) ==
                       ((lim[i] == '0) ? {LIMW{1'b1}} : lim[i])) begin
            cnt[i]   <= '0;
            rch[i]   <= 1'b1;
            irq_q[i] <= 1'b1;
          end else begin
            cnt[i] <= {{(CNTW-LIMW){1'b0}}, cnt[i][LIMW-1:0] + LIMW'(1)};
          end
        end

        if (cpu_wr && bus_cpu == CW'(i)) begin
          if (cfg[i]) begin
            case (bus_word)
              3'd0: begin cnt[i][CNTW-1:23] <= bus_wdata[30:0]; svld[i] <= 1'b0; end
              3'd1: begin cnt[i][22:0] <= bus_wdata[31:9]; svld[i] <= 1'b0; end
              3'd3: run[i] <= bus_wdata[0];
              default: ;
            endcase
          end else begin
            case (bus_word)
              3'd0: begin
                lim[i]   <= bus_wdata[30:9];
                cnt[i]   <= '0;
                rch[i]   <= 1'b0;
                irq_q[i] <= 1'b0;
              end
              3'd2: lim[i] <= bus_wdata[30:9];
              default: ;
            endcase
          end
        end

        if (cfg_wr && bus_wdata[i] != cfg[i]) begin
          cnt[i]  <= '0;
          lim[i]  <= '0;
          rch[i]  <= 1'b0;
          svld[i] <= 1'b0;
          if (bus_wdata[i]) begin
            irq_q[i] <= 1'b0;
            run[i]   <= 1'b0;
          end else begin
            run[i]   <= 1'b1;
          end
        end
      end
      if (cfg_wr) cfg <= bus_wdata[NCPU-1:0];
    end
  end
endmodule

// File: rtl/cpu_timer_set_chk.sv
module cpu_timer_set_chk #(
  parameter int NCPU = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic            bus_sys,
  input logic [2:0]      bus_word,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [NCPU-1:0] cfg,
  input logic [NCPU-1:0] irq
);
  wire cfg_wr = bus_wr && bus_sys && bus_word == 3'd4;

  a_r6_cfg_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(cfg));

  a_r6_cfg_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> cfg == $past(bus_wdata[NCPU-1:0]));

  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    a_r11_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[i] |-> !irq[i]);
    a_r13_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(tick));
    a_r7_enter_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg[i]) |-> !irq[i]);
  end
endmodule

bind cpu_timer_set cpu_timer_set_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_sys(bus_sys), .bus_word(bus_word), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cfg(cfg), .irq(irq_q)
);

// File: tb/tb_cpu_timer_set.sv
module tb_cpu_timer_set;
  localparam int NCPU = 2;
  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0, bus_rd = 0, bus_sys = 0;
  logic [0:0]  bus_cpu = 0;
  logic [2:0]  bus_word = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NCPU-1:0] irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cpu_timer_set #(.NCPU(NCPU)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic s, input logic c, input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sys = s; bus_cpu = c; bus_word = w; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic s, input logic c, input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_sys = s; bus_cpu = c; bus_word = w; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1, 0, 4, v); chk("R1 cfg", v, 0);
    rd(0, 0, 1, v); chk("R1 count", v, 0);
    rd(0, 1, 3, v); chk("R1 running", v, 1);
    chk("R1 irq", {30'b0, irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    ticks(5);
    rd(0, 0, 1, v); chk("R2 count5", v, 32'hA00);
    repeat (10) @(negedge clk);
    rd(0, 0, 1, v); chk("R13 no tick", v, 32'hA00);
  endtask

  task automatic t_limit();
    logic [31:0] v;
    wr(0, 0, 0, 32'h600);
    rd(0, 0, 1, v); chk("R4 w0 zeroes", v, 0);
    ticks(2); chk("R2 irq before", {31'b0, irq[0]}, 0);
    ticks(1); chk("R2 irq at limit", {31'b0, irq[0]}, 1);
    rd(0, 0, 1, v); chk("R2 wrapped", v, 32'h8000_0000);
    rd(0, 0, 0, v); chk("R3 limit read", v, 32'h8000_0600);
    chk("R3 irq cleared", {31'b0, irq[0]}, 0);
    rd(0, 0, 0, v); chk("R3 reached cleared", v, 32'h600);
  endtask

  task automatic t_norst();
    logic [31:0] v;
    wr(0, 0, 0, 32'h1400);
    ticks(4);
    wr(0, 0, 2, 32'h2800);
    rd(0, 0, 1, v); chk("R4 w2 keeps count", v, 32'h800);
    rd(0, 0, 0, v); chk("R4 w2 limit", v, 32'h2800);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(0, 0, 1, 32'hFFFF_FFFF);
    wr(0, 0, 3, 0);
    rd(0, 0, 1, v); chk("R5 w1 ignored", v, 32'h800);
    rd(0, 0, 3, v); chk("R5 w3 ignored", v, 1);
    rd(0, 0, 2, v); chk("R5 w2 reads 0", v, 0);
    rd(1, 0, 0, v); chk("R6 sys w0 zero", v, 0);
  endtask

  task automatic t_user();
    logic [31:0] v;
    wr(0, 1, 0, 32'h200);
    ticks(1); chk("R2 cpu1 irq", {31'b0, irq[1]}, 1);
    wr(1, 0, 4, 32'h2);
    chk("R7 irq dropped", {31'b0, irq[1]}, 0);
    rd(1, 0, 4, v); chk("R6 cfg readback", v, 2);
    rd(0, 1, 3, v); chk("R7 stopped", v, 0);
    rd(0, 1, 0, v); chk("R7 reached clear", v, 0);
    rd(0, 1, 1, v); chk("R7 count clear", v, 0);
    rd(0, 0, 3, v); chk("R6 cpu0 untouched", v, 1);
    ticks(3);
    rd(0, 1, 1, v); chk("R8 stopped ignores tick", v, 0);
    wr(0, 1, 3, 1);
    rd(0, 1, 3, v); chk("R8 started", v, 1);
    ticks(3);
    rd(0, 1, 1, v); chk("R8 running counts", v, 32'h600);
    wr(0, 1, 3, 0);
    ticks(2);
    rd(0, 1, 1, v); chk("R8 stop holds", v, 32'h600);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(0, 1, 0, 32'h1234_5678);
    wr(0, 1, 1, 32'hABCD_E000);
    rd(0, 1, 0, v); chk("R9 high", v, 32'h1234_5678);
    rd(0, 1, 1, v); chk("R9 low", v, 32'hABCD_E000);
  endtask

  task automatic t_coherent();
    logic [31:0] v;
    wr(0, 1, 0, 32'h5);
    wr(0, 1, 1, 32'hFFFF_FE00);
    wr(0, 1, 3, 1);
    rd(0, 1, 0, v); chk("R10 high before", v, 5);
    ticks(1);
    rd(0, 1, 1, v); chk("R10 captured low", v, 32'hFFFF_FE00);
    rd(0, 1, 1, v); chk("R10 live low", v, 0);
    rd(0, 1, 0, v); chk("R10 carried high", v, 6);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(0, 1, 0, 32'h7FFF_FFFF);
    wr(0, 1, 1, 32'hFFFF_FE00);
    ticks(1);
    chk("R11 no irq", {31'b0, irq[1]}, 0);
    rd(0, 1, 0, v); chk("R11 reached", v, 32'h8000_0000);
    rd(0, 1, 1, v); chk("R11 low zero", v, 0);
  endtask

  task automatic t_back();
    logic [31:0] v;
    wr(1, 0, 4, 0);
    rd(0, 1, 3, v); chk("R12 running", v, 1);
    rd(0, 1, 0, v); chk("R12 limit and flag", v, 0);
    rd(0, 1, 1, v); chk("R12 count", v, 0);
    ticks(2);
    rd(0, 1, 1, v); chk("R12 counts", v, 32'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_limit();
    t_norst();
    t_ignore();
    t_user();
    t_load();
    t_coherent();
    t_wrap();
    t_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule